// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable memory with a fixed two-cycle pipeline. Address, operation type and byte-write mask are sampled on one rising edge. The matching data word crosses the shared data bus two edges later. This holds for both reads and writes, so a controller can issue reads and writes in any order on consecutive cycles and no idle bus cycles are needed between them.

A cycle can start a new operation, continue a 4-word burst, or deselect the device. When a burst continues, the low two address bits step in either linear or interleaved order, and the operation type of the burst stays the same. A clock-enable input freezes the whole pipeline. An asynchronous output-enable input gates only the read drivers.

The data bus is brought out as separate input, output and drive-enable signals, so the drive enable can feed a pad or an on-chip tristate. The word is four 9-bit byte lanes, and lane i occupies bits 9i+8 down to 9i. The array holds 2^ADDR_W words.

Top module: `zbt_sram`

## Requirements
- R1: A read accepted at edge k places the stored word on `bus_out` with `bus_drive` high right after edge k+2, counting only edges where `clk_en_n` is low, provided `out_en_n` is low.
- R2: A write accepted at edge k stores the value on `bus_in` at edge k+2 into the addressed word.
- R3: A read, a write and another read may be issued on consecutive edges, with each data phase landing two edges after its own address.
- R4: While `clk_en_n` is high, all inputs are ignored except `out_en_n` and reset, and every register holds its value, including the pipeline, the output word and the burst state.
- R5: A new operation starts only when `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0 and `burst_adv`=0. `rd_nwr`=1 selects a read and 0 selects a write. When `burst_adv`=0 and any select is inactive, the cycle is a deselect.
- R6: After a deselect, reads and writes that were already issued still finish on their normal cycles.
- R7: `bus_drive` is low right after edge k+2 when edge k was a deselect or started a write.
- R8: With `burst_adv`=1 after an active operation, the type is repeated. With `burst_ilv`=0, the low two address bits are the loaded low bits plus the burst count, modulo 4, and the upper bits are unchanged.
- R9: With `burst_ilv`=1, the low two address bits are the loaded low bits XOR the burst count. `burst_ilv` is held steady during a burst.
- R10: `byte_we[i]`=1 writes lane i. A lane whose enable bit was 0 in the address cycle keeps its stored value.
- R11: `out_en_n`=1 forces `bus_drive` low at once, without a clock edge, and leaves the pipeline and the output word untouched.
- R12: `rst_n` low at a clock edge clears the pipeline, so `bus_drive` is low and no operation is pending. `burst_adv`=1 after a deselect starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset of the pipeline, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| burst_adv | input | 1 | 1 = advance burst, 0 = load new address |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| byte_we | input | 4 | Per-lane write enables, active high |
| addr | input | ADDR_W | Word address |
| out_en_n | input | 1 | Asynchronous read-driver enable, active low |
| bus_in | input | 36 | Write data from the bus |
| bus_out | output | 36 | Read data toward the bus |
| bus_drive | output | 1 | Bus driver enable |

## Verification
The bench interleaves writes and reads to the same addresses on consecutive cycles. A pipeline that was one stage short or long, or that read before an earlier write had committed, would return the wrong word on the wrong cycle. It runs full 4-word bursts in both orders starting from a non-zero low address, which exposes a missing wrap or an order mix-up. It applies a partial byte mask and checks that the untouched lanes kept their old contents. Clock-enable stalls are placed both while the pipeline is full and while it is empty, and a read is issued during a stall: a design that let any stage slip would shift or invent a data phase. Deselects of each select polarity, and advance cycles after a deselect, must produce no drive while earlier reads still complete.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    // Low address bits of a burst step: linear adds, interleaved XORs.
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] cnt,
        input logic               ilv
    );
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction
endpackage

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/zbt_issue.sv
module zbt_issue
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              rd_nwr,
    input  logic              burst_adv,
    input  logic              burst_ilv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  byte_we,
    output logic              iss_valid,
    output logic              iss_wr,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [LANES-1:0]  iss_be
);
    typedef struct packed {
        logic               valid;
        logic               wr;
        logic [ADDR_W-1:0]  addr;
        logic [LANES-1:0]   be;
        logic [BURST_W-1:0] cnt;
        logic [BURST_W-1:0] base;
    } iss_t;

    iss_t st_d, st_q;
    logic sel;

    assign sel = !sel_a_n && sel_b && !sel_c_n;

    always_comb begin
        st_d = st_q;
        if (!clk_en_n) begin
            if (!burst_adv) begin
                if (sel) begin
                    st_d.valid = 1'b1;
                    st_d.wr    = !rd_nwr;
                    st_d.addr  = addr;
                    st_d.be    = byte_we;
                    st_d.cnt   = '0;
                    st_d.base  = addr[BURST_W-1:0];
                end else begin
                    st_d.valid = 1'b0;
                    st_d.be    = '0;
                end
            end else if (st_q.valid) begin
                st_d.cnt = st_q.cnt + BURST_W'(1);
                st_d.addr[BURST_W-1:0] = burst_low(st_q.base, st_d.cnt, burst_ilv);
                st_d.be  = byte_we;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign iss_valid = st_q.valid;
    assign iss_wr    = st_q.wr;
    assign iss_addr  = st_q.addr;
    assign iss_be    = st_q.be;

    // R5: a selected load cycle captures the address and type
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !burst_adv && sel) |=>
            (iss_valid && iss_addr == $past(addr) && iss_wr == !$past(rd_nwr)));

    // R5: an unselected load cycle issues nothing
    p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !burst_adv && !sel) |=> !iss_valid);

    // R8: a burst step keeps the type and the upper address bits
    p_burst_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && burst_adv && iss_valid) |=>
            (iss_valid && iss_wr == $past(iss_wr) &&
             iss_addr[ADDR_W-1:BURST_W] == $past(iss_addr[ADDR_W-1:BURST_W])));

    // R8: linear order moves the low bits up by one each step
    p_burst_lin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && burst_adv && iss_valid && !burst_ilv && $stable(burst_ilv)) |=>
            (iss_addr[BURST_W-1:0] == $past(iss_addr[BURST_W-1:0]) + BURST_W'(1)));

    // R4: a stalled cycle changes nothing in the issue stage
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(st_q));
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              rd_nwr,
    input  logic              burst_adv,
    input  logic              burst_ilv,
    input  logic [LANES-1:0]  byte_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              out_en_n,
    input  logic [WORD_W-1:0] bus_in,
    output logic [WORD_W-1:0] bus_out,
    output logic              bus_drive
);
    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic              drive;
        logic [WORD_W-1:0] rd;
    } pipe_t;

    logic              iss_valid;
    logic              iss_wr;
    logic [ADDR_W-1:0] iss_addr;
    logic [LANES-1:0]  iss_be;
    logic [LANES-1:0]  lane_we;
    logic [WORD_W-1:0] arr_rdata;
    pipe_t             p_d, p_q;

    zbt_issue #(.ADDR_W(ADDR_W)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en_n  (clk_en_n),
        .sel_a_n   (sel_a_n),
        .sel_b     (sel_b),
        .sel_c_n   (sel_c_n),
        .rd_nwr    (rd_nwr),
        .burst_adv (burst_adv),
        .burst_ilv (burst_ilv),
        .addr      (addr),
        .byte_we   (byte_we),
        .iss_valid (iss_valid),
        .iss_wr    (iss_wr),
        .iss_addr  (iss_addr),
        .iss_be    (iss_be)
    );

    // Second stage: the data phase of the operation issued one edge earlier.
    always_comb begin
        p_d = p_q;
        if (!clk_en_n) begin
            p_d.valid = iss_valid;
            p_d.wr    = iss_wr;
            p_d.addr  = iss_addr;
            p_d.be    = iss_be;
            p_d.drive = p_q.valid && !p_q.wr;
            if (p_d.drive) begin
                p_d.rd = arr_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = !clk_en_n && rst_n && p_q.valid && p_q.wr && p_q.be[g];

        zbt_lane_array #(.ADDR_W(ADDR_W), .DATA_W(LANE_W)) u_lane (
            .clk   (clk),
            .we    (lane_we[g]),
            .waddr (p_q.addr),
            .wdata (bus_in[g*LANE_W +: LANE_W]),
            .raddr (p_q.addr),
            .rdata (arr_rdata[g*LANE_W +: LANE_W])
        );
    end

    assign bus_out   = p_q.rd;
    assign bus_drive = p_q.drive && !out_en_n;

    // R4: a stalled cycle freezes the output word and its drive state
    p_hold_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(bus_out) && $stable(p_q.drive)));

    // R7: a write issued two live edges back leaves the bus undriven
    p_write_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && $past(!clk_en_n) && $past(iss_valid && iss_wr)) |=> !bus_drive);

    // R1: a read issued two live edges back drives the bus unless gated
    p_read_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && $past(!clk_en_n) && $past(iss_valid && !iss_wr)) |=>
            (bus_drive || out_en_n));

    // R10: no lane is written while the block is stalled
    p_no_stall_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |-> (lane_we == '0));
endmodule

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;
    import zbt_pkg::*;

    localparam int AW   = 10;
    localparam int NVEC = 30;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            clk_en_n;
    logic            sel_a_n, sel_b, sel_c_n;
    logic            rd_nwr, burst_adv, burst_ilv;
    logic [3:0]      byte_we;
    logic [AW-1:0]   addr;
    logic            out_en_n;
    logic [35:0]     bus_in;
    logic [35:0]     bus_out;
    logic            bus_drive;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    zbt_sram #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .rd_nwr(rd_nwr), .burst_adv(burst_adv), .burst_ilv(burst_ilv),
        .byte_we(byte_we), .addr(addr), .out_en_n(out_en_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_drive(bus_drive)
    );

    typedef struct packed {
        logic          cen_n;
        logic [2:0]    cs;     // {sel_a_n, sel_b, sel_c_n}
        logic          adv;
        logic          rd;
        logic          ilv;
        logic [3:0]    be;
        logic [AW-1:0] addr;
        logic [35:0]   din;
        logic          exp_oe;
        logic [35:0]   exp_dq;
        logic [3:0]    req;
    } vec_t;

    localparam logic [35:0] A0 = 36'h1_2345_6789;
    localparam logic [35:0] A1 = 36'hA_BCDE_F012;
    localparam logic [35:0] BV = 36'h5_5555_5555;
    localparam logic [35:0] MV = {A0[35:18], BV[17:0]};
    localparam logic [35:0] C0 = 36'h0_1111_1111;
    localparam logic [35:0] C1 = 36'h2_2222_2222;
    localparam logic [35:0] C2 = 36'h3_3333_3333;
    localparam logic [35:0] C3 = 36'h4_4444_4444;
    localparam logic [2:0]  S  = 3'b010;
    localparam logic [35:0] Z  = 36'h0;

    // Each row: inputs for one edge, then the drive state expected after it.
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, S,      1'b0, 1'b0, 1'b0, 4'hF, 10'd8,  Z,  1'b0, Z,  4'd5},  // R5 write 8
        '{1'b0, S,      1'b0, 1'b0, 1'b0, 4'hF, 10'd9,  Z,  1'b0, Z,  4'd5},  // write 9
        '{1'b0, S,      1'b0, 1'b1, 1'b0, 4'hF, 10'd8,  A0, 1'b0, Z,  4'd7},  // R2 data A0, R7 write off
        '{1'b0, S,      1'b0, 1'b0, 1'b0, 4'h3, 10'd8,  A1, 1'b0, Z,  4'd7},  // R10 partial write 8
        '{1'b0, S,      1'b0, 1'b1, 1'b0, 4'hF, 10'd9,  Z,  1'b1, A0, 4'd1},  // R1 read 8
        '{1'b0, S,      1'b0, 1'b1, 1'b0, 4'hF, 10'd8,  BV, 1'b0, Z,  4'd3},  // R3 write slot
        '{1'b0, 3'b110, 1'b0, 1'b1, 1'b0, 4'hF, 10'd0,  Z,  1'b1, A1, 4'd3},  // R3 read 9
        '{1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 4'hF, 10'd0,  Z,  1'b1, MV, 4'd10}, // R10 merged lanes
        '{1'b0, 3'b011, 1'b0, 1'b1, 1'b0, 4'hF, 10'd0,  Z,  1'b0, Z,  4'd7},  // R7 deselect off
        '{1'b1, S,      1'b0, 1'b1, 1'b0, 4'hF, 10'd9,  Z,  1'b0, Z,  4'd4},  // R4 stalled read
        '{1'b0, S,      1'b0, 1'b0, 1'b0, 4'hF, 10'd17, Z,  1'b0, Z,  4'd5},  // burst write at 17
        '{1'b0, S,      1'b1, 1'b1, 1'b0, 4'hF, 10'd0,  Z,  1'b0, Z,  4'd4},  // R4 stalled read gone
        '{1'b0, S,      1'b1, 1'b1, 1'b0, 4'hF, 10'd0,  C0, 1'b0, Z,  4'd8},  // R8 -> 19
        '{1'b0, S,      1'b1, 1'b1, 1'b0, 4'hF, 10'd0,  C1, 1'b0, Z,  4'd8},  // R8 wrap -> 16
        '{1'b0, S,      1'b0, 1'b1, 1'b1, 4'hF, 10'd17, C2, 1'b0, Z,  4'd8},  // burst read at 17
        '{1'b0, S,      1'b1, 1'b0, 1'b1, 4'hF, 10'd0,  C3, 1'b0, Z,  4'd9},  // R9 -> 16
        '{1'b0, S,      1'b1, 1'b0, 1'b1, 4'hF, 10'd0,  Z,  1'b1, C0, 4'd9},  // R9 -> 19
        '{1'b0, S,      1'b1, 1'b0, 1'b1, 4'hF, 10'd0,  Z,  1'b1, C3, 4'd9},  // R9 -> 18
        '{1'b0, 3'b110, 1'b0, 1'b1, 1'b0, 4'hF, 10'd0,  Z,  1'b1, C2, 4'd9},  // R9 word 19
        '{1'b0, 3'b110, 1'b0, 1'b1, 1'b0, 4'hF, 10'd0,  Z,  1'b1, C1, 4'd6},  // R6 pending read done
        '{1'b0, 3'b110, 1'b0, 1'b1, 1'b0, 4'hF, 10'd0,  Z,  1'b0, Z,  4'd7},
        '{1'b0, S,      1'b1, 1'b1, 1'b0, 4'hF, 10'd0,  Z,  1'b0, Z,  4'd12}, // R12 advance after deselect
        '{1'b0, 3'b110, 1'b0, 1'b1, 1'b0, 4'hF, 10'd0,  Z,  1'b0, Z,  4'd12},
        '{1'b0, 3'b110, 1'b0, 1'b1, 1'b0, 4'hF, 10'd0,  Z,  1'b0, Z,  4'd12}, // R12 no op issued
        '{1'b0, S,      1'b0, 1'b1, 1'b0, 4'hF, 10'd9,  Z,  1'b0, Z,  4'd4},
        '{1'b1, 3'b110, 1'b0, 1'b1, 1'b0, 4'hF, 10'd0,  Z,  1'b0, Z,  4'd4},  // R4 stall, full pipe
        '{1'b1, 3'b110, 1'b0, 1'b1, 1'b0, 4'hF, 10'd0,  Z,  1'b0, Z,  4'd4},
        '{1'b0, 3'b110, 1'b0, 1'b1, 1'b0, 4'hF, 10'd0,  Z,  1'b0, Z,  4'd4},
        '{1'b0, 3'b110, 1'b0, 1'b1, 1'b0, 4'hF, 10'd0,  Z,  1'b1, A1, 4'd4},  // R4 read after stall
        '{1'b0, 3'b110, 1'b0, 1'b1, 1'b0, 4'hF, 10'd0,  Z,  1'b0, Z,  4'd6}
    };

    task automatic check(input string what, input int req,
                         input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        clk_en_n  = v.cen_n;
        {sel_a_n, sel_b, sel_c_n} = v.cs;
        burst_adv = v.adv;
        rd_nwr    = v.rd;
        burst_ilv = v.ilv;
        byte_we   = v.be;
        addr      = v.addr;
        bus_in    = v.din;
    endtask

    task automatic idle();
        clk_en_n = 1'b0;
        {sel_a_n, sel_b, sel_c_n} = 3'b110;
        burst_adv = 1'b0;
        rd_nwr = 1'b1;
        burst_ilv = 1'b0;
        byte_we = 4'hF;
        addr = '0;
        bus_in = '0;
    endtask

    initial begin
        rst_n = 1'b0;
        out_en_n = 1'b0;
        idle();
        repeat (3) @(posedge clk);
        #5;
        check("bus_drive in reset", 12, {35'b0, bus_drive}, 36'h0); // R12
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            @(posedge clk);
            #5;
            check($sformatf("row %0d bus_drive", i), int'(VEC[i].req),
                  {35'b0, bus_drive}, {35'b0, VEC[i].exp_oe});
            if (VEC[i].exp_oe) begin
                check($sformatf("row %0d bus_out", i), int'(VEC[i].req),
                      bus_out, VEC[i].exp_dq);
            end
        end

        // R11: output enable gates the drivers without a clock edge
        @(negedge clk);
        apply('{1'b0, S, 1'b0, 1'b1, 1'b0, 4'hF, 10'd9, Z, 1'b0, Z, 4'd11});
        @(negedge clk);
        idle();
        @(negedge clk);
        @(posedge clk);
        #5;
        check("read drive before gating", 11, {35'b0, bus_drive}, 36'h1);
        out_en_n = 1'b1;
        #1;
        check("drive gated off", 11, {35'b0, bus_drive}, 36'h0);
        out_en_n = 1'b0;
        #1;
        check("drive restored", 11, {35'b0, bus_drive}, 36'h1);
        check("word kept under gating", 11, bus_out, A1);

        // R12: reset in mid-stream drops a pending read
        @(negedge clk);
        apply('{1'b0, S, 1'b0, 1'b1, 1'b0, 4'hF, 10'd8, Z, 1'b0, Z, 4'd12});
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(posedge clk);
        #5;
        check("drive after reset", 12, {35'b0, bus_drive}, 36'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        check("cancelled read stays off", 12, {35'b0, bus_drive}, 36'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule